// File: doc/BRIEF.md
# Unified Zero-Compare Unit

This block decides how a 64-bit operand relates to zero and reports the answer as four flags: equal, less-than, greater-than and unordered. A compare or conditional-branch stage feeds the operand and a two-bit mode, and consumes the flags in the same cycle. The block is purely combinational.

The mode picks one of three readings of the operand: a two's-complement integer, an unsigned integer, or an IEEE 754 double. All three readings come from one set of field terms taken from the double layout. These terms are the sign bit, an all-zero exponent, an all-ones exponent and an all-zero fraction. The integer flags are built from the same terms, so no separate 64-bit zero detector exists for the integer paths.

In double mode, the unit sorts the operand into ten classes: positive and negative zero, denormal, normal and infinity, plus quiet and signalling NaN. The flags are then resolved from that class. The block has no clock and no state, so it has no states or transitions. The checker and bench use a clock for sampling only.

Top module: `zc_unit`

## Requirements
- R1: Mode code 2'b00 selects signed integer, 2'b01 unsigned integer, 2'b10 double; code 2'b11 is reserved and drives all four flags low.
- R2: In signed mode, equal is high exactly when all 64 bits are zero, less-than equals bit 63, greater-than is high for any other value, and unordered is low.
- R3: In unsigned mode, less-than is always low, equal is high exactly when all 64 bits are zero, greater-than is high for every nonzero value, and unordered is low.
- R4: In double mode, an operand whose bits 62:0 are all zero (positive or negative zero) gives equal high and the other flags low.
- R5: In double mode, an operand with exponent bits 62:52 all ones and a nonzero fraction in bits 51:0 (any NaN, quiet or signalling) gives unordered high and equal, less-than and greater-than low.
- R6: In double mode, a denormal (exponent bits all zero, fraction nonzero) is nonzero: less-than if bit 63 is set, otherwise greater-than.
- R7: In double mode, normals and infinities (exponent all ones, fraction zero) compare by sign bit 63 alone: less-than when set, greater-than when clear.
- R8: In every mode at most one of the four flags is high, and in modes 00, 01 and 10 exactly one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_operand | input | 64 | Value compared against zero |
| i_mode | input | 2 | Interpretation select (see R1) |
| o_eq | output | 1 | Operand equals zero |
| o_lt | output | 1 | Operand below zero |
| o_gt | output | 1 | Operand above zero |
| o_unord | output | 1 | Operand is a NaN (double mode only) |

## Verification
The unit holds no state. A wrong internal term shows on the flags in the same evaluation that the operand changes. A stuck or miswired field term shows up as a flag that is wrong for a whole class of operands. Examples are negative zero reading as less-than, a denormal reading as equal, or a NaN leaking a less-than. The bench therefore aims directed cases and biased random operands at every exponent/fraction class, in every mode, and checks the flags after each change.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [1:0] {
        MODE_SINT = 2'b00,
        MODE_UINT = 2'b01,
        MODE_DBL  = 2'b10,
        MODE_RSV  = 2'b11
    } zc_mode_e;

    typedef enum logic [3:0] {
        CLS_POS_ZERO,
        CLS_NEG_ZERO,
        CLS_POS_SUB,
        CLS_NEG_SUB,
        CLS_POS_NORM,
        CLS_NEG_NORM,
        CLS_POS_INF,
        CLS_NEG_INF,
        CLS_QNAN,
        CLS_SNAN
    } zc_class_e;

    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic frac_zero;
        logic frac_msb;
    } zc_terms_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
        logic unord;
    } zc_flags_t;

endpackage

// File: rtl/zc_field_decode.sv
module zc_field_decode
    import zc_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] i_value,
    output zc_terms_t         o_terms
);
    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    assign exp_field  = i_value[DATA_W-2 -: EXP_W];
    assign frac_field = i_value[FRAC_W-1:0];

    always_comb begin
        o_terms.sign      = i_value[DATA_W-1];
        o_terms.exp_zero  = ~|exp_field;
        o_terms.exp_ones  = &exp_field;
        o_terms.frac_zero = ~|frac_field;
        o_terms.frac_msb  = frac_field[FRAC_W-1];
    end
endmodule

// File: rtl/zc_fp_classify.sv
module zc_fp_classify
    import zc_pkg::*;
(
    input  zc_terms_t i_terms,
    output zc_class_e o_class
);
    always_comb begin
        unique case ({i_terms.exp_ones, i_terms.exp_zero, i_terms.frac_zero})
            3'b011:  o_class = i_terms.sign ? CLS_NEG_ZERO : CLS_POS_ZERO;
            3'b010:  o_class = i_terms.sign ? CLS_NEG_SUB  : CLS_POS_SUB;
            3'b101:  o_class = i_terms.sign ? CLS_NEG_INF  : CLS_POS_INF;
            3'b100:  o_class = i_terms.frac_msb ? CLS_QNAN : CLS_SNAN;
            default: o_class = i_terms.sign ? CLS_NEG_NORM : CLS_POS_NORM;
        endcase
    end
endmodule

// File: rtl/zc_flag_select.sv
module zc_flag_select
    import zc_pkg::*;
(
    input  zc_mode_e  i_mode,
    input  zc_terms_t i_terms,
    input  zc_class_e i_class,
    output zc_flags_t o_flags
);
    zc_flags_t int_flags;
    zc_flags_t uns_flags;
    zc_flags_t dbl_flags;
    logic      all_zero;

    // whole word zero reuses the field terms plus the sign bit
    assign all_zero = i_terms.exp_zero & i_terms.frac_zero & ~i_terms.sign;

    always_comb begin
        int_flags = '{eq: all_zero, lt: i_terms.sign,
                      gt: ~i_terms.sign & ~all_zero, unord: 1'b0};
        uns_flags = '{eq: all_zero, lt: 1'b0, gt: ~all_zero, unord: 1'b0};
    end

    always_comb begin
        dbl_flags = '0;
        unique case (i_class)
            CLS_POS_ZERO, CLS_NEG_ZERO:              dbl_flags.eq    = 1'b1;
            CLS_NEG_SUB, CLS_NEG_NORM, CLS_NEG_INF:  dbl_flags.lt    = 1'b1;
            CLS_POS_SUB, CLS_POS_NORM, CLS_POS_INF:  dbl_flags.gt    = 1'b1;
            CLS_QNAN, CLS_SNAN:                      dbl_flags.unord = 1'b1;
            default:                                 dbl_flags       = '0;
        endcase
    end

    always_comb begin
        unique case (i_mode)
            MODE_SINT: o_flags = int_flags;
            MODE_UINT: o_flags = uns_flags;
            MODE_DBL:  o_flags = dbl_flags;
            default:   o_flags = '0;
        endcase
    end
endmodule

// File: rtl/zc_unit.sv
module zc_unit
    import zc_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] i_operand,
    input  logic [1:0]        i_mode,
    output logic              o_eq,
    output logic              o_lt,
    output logic              o_gt,
    output logic              o_unord
);
    zc_terms_t terms;
    zc_class_e fp_class;
    zc_flags_t flags;

    zc_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
        .i_value (i_operand),
        .o_terms (terms)
    );

    zc_fp_classify u_classify (
        .i_terms (terms),
        .o_class (fp_class)
    );

    zc_flag_select u_select (
        .i_mode  (zc_mode_e'(i_mode)),
        .i_terms (terms),
        .i_class (fp_class),
        .o_flags (flags)
    );

    assign o_eq    = flags.eq;
    assign o_lt    = flags.lt;
    assign o_gt    = flags.gt;
    assign o_unord = flags.unord;
endmodule

// File: rtl/zc_unit_chk.sv
module zc_unit_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input logic [DATA_W-1:0] i_operand,
    input logic [1:0]        i_mode,
    input logic              o_eq,
    input logic              o_lt,
    input logic              o_gt,
    input logic              o_unord
);
    logic [3:0]  fl;
    logic        known;
    logic        exp_max;
    logic        exp_min;
    logic        frac_nz;

    assign fl      = {o_eq, o_lt, o_gt, o_unord};
    assign known   = !$isunknown({i_operand, i_mode});
    assign exp_max = (i_operand[DATA_W-2 -: EXP_W] == {EXP_W{1'b1}});
    assign exp_min = (i_operand[DATA_W-2 -: EXP_W] == '0);
    assign frac_nz = (i_operand[FRAC_W-1:0] != '0);

    always_comb begin
        if (known) begin
            AST_AT_MOST_ONE: assert ($onehot0(fl)); // R8
            AST_RSV_QUIET: assert (i_mode != 2'b11 || fl == 4'b0000); // R1
            AST_NAN_UNORD: assert (!(i_mode == 2'b10 && exp_max && frac_nz) || fl == 4'b0001); // R5
            AST_SIGNED_ZERO_EQ: assert (!(i_mode == 2'b10 && i_operand[DATA_W-2:0] == '0) || fl == 4'b1000); // R4
            AST_UNS_NEVER_LT: assert (i_mode != 2'b01 || !o_lt); // R3
            AST_INT_NO_UNORD: assert (i_mode[1] || !o_unord); // R2
            AST_DENORM_SIGNED: assert (!(i_mode == 2'b10 && exp_min && frac_nz) || (o_lt == i_operand[DATA_W-1] && o_gt == !i_operand[DATA_W-1])); // R6
            AST_INF_BY_SIGN: assert (!(i_mode == 2'b10 && exp_max && !frac_nz) || (o_lt == i_operand[DATA_W-1] && o_gt == !i_operand[DATA_W-1])); // R7
        end
    end
endmodule

bind zc_unit zc_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .i_operand (i_operand),
    .i_mode    (i_mode),
    .o_eq      (o_eq),
    .o_lt      (o_lt),
    .o_gt      (o_gt),
    .o_unord   (o_unord)
);

// File: tb/sim_zc_unit.sv
`timescale 1ns/1ps
module sim_zc_unit;
    logic        clk = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  mode = 2'b00;
    logic        eq, lt, gt, unord;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    zc_unit u0 (
        .i_operand (operand),
        .i_mode    (mode),
        .o_eq      (eq),
        .o_lt      (lt),
        .o_gt      (gt),
        .o_unord   (unord)
    );

    // expected {eq, lt, gt, unord} from the requirements
    function automatic logic [3:0] expect_flags(input logic [1:0] m, input logic [63:0] v);
        logic [10:0] e;
        logic [51:0] f;
        e = v[62:52];
        f = v[51:0];
        case (m)
            2'b00: begin // R2
                if (v == 64'd0) return 4'b1000;
                return v[63] ? 4'b0100 : 4'b0010;
            end
            2'b01: return (v == 64'd0) ? 4'b1000 : 4'b0010; // R3
            2'b10: begin
                if (v[62:0] == 63'd0) return 4'b1000;            // R4
                if (e == 11'h7FF && f != 52'd0) return 4'b0001;  // R5
                return v[63] ? 4'b0100 : 4'b0010;                // R6 R7
            end
            default: return 4'b0000; // R1
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] m, input logic [63:0] v);
        if (m == 2'b11) return "R1";
        if (m == 2'b00) return "R2";
        if (m == 2'b01) return "R3";
        if (v[62:0] == 63'd0) return "R4";
        if (v[62:52] == 11'h7FF && v[51:0] != 52'd0) return "R5";
        if (v[62:52] == 11'h000) return "R6";
        return "R7";
    endfunction

    task automatic apply(input logic [1:0] m, input logic [63:0] v);
        logic [3:0] got;
        logic [3:0] exp_f;
        @(posedge clk);
        {mode, operand} = {m, v};
        @(negedge clk);
        got   = {eq, lt, gt, unord};
        exp_f = expect_flags(m, v);
        n_checks++;
        if (got !== exp_f) begin
            n_fail++;
            $display("FAIL %s mode=%b op=%h actual=%b expected=%b",
                     tag_for(m, v), m, v, got, exp_f);
        end
        n_checks++;
        if ($countones(got) > 1 || (m != 2'b11 && $countones(got) != 1)) begin
            n_fail++;
            $display("FAIL R8 mode=%b op=%h actual=%b expected=one-hot", m, v, got);
        end
    endtask

    function automatic logic [63:0] rand_operand();
        logic [63:0] v;
        logic [2:0]  pick;
        v    = {$urandom, $urandom};
        pick = 3'($urandom % 8);
        case (pick)
            3'd0: v[62:52] = 11'h000;
            3'd1: v[62:52] = 11'h7FF;
            3'd2: begin v[62:52] = 11'h7FF; v[51:0] = '0; end
            3'd3: v[62:0] = '0;
            3'd4: begin v[62:52] = 11'h000; v[51:1] = '0; v[0] = 1'b1; end
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240327));
        // reset state: zero operand, signed mode
        apply(2'b00, 64'd0);                        // R2 all zero -> eq
        // R1 reserved mode
        apply(2'b11, 64'd0);
        apply(2'b11, 64'h8000_0000_0000_0000);
        apply(2'b11, 64'h7FF8_0000_0000_0000);
        // R2 signed
        apply(2'b00, 64'h8000_0000_0000_0000);
        apply(2'b00, 64'h0000_0000_0000_0001);
        apply(2'b00, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(2'b00, 64'h7FFF_FFFF_FFFF_FFFF);
        // R3 unsigned
        apply(2'b01, 64'd0);
        apply(2'b01, 64'h8000_0000_0000_0000);
        apply(2'b01, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(2'b01, 64'h0010_0000_0000_0000);
        // R4 signed zeros
        apply(2'b10, 64'h0000_0000_0000_0000);
        apply(2'b10, 64'h8000_0000_0000_0000);
        // R5 NaNs
        apply(2'b10, 64'h7FF8_0000_0000_0000);
        apply(2'b10, 64'hFFF0_0000_0000_0001);
        apply(2'b10, 64'h7FF7_FFFF_FFFF_FFFF);
        // R6 denormals
        apply(2'b10, 64'h0000_0000_0000_0001);
        apply(2'b10, 64'h800F_FFFF_FFFF_FFFF);
        // R7 infinities and normals
        apply(2'b10, 64'h7FF0_0000_0000_0000);
        apply(2'b10, 64'hFFF0_0000_0000_0000);
        apply(2'b10, 64'h3FF0_0000_0000_0000);
        apply(2'b10, 64'hC009_21FB_5444_2D18);
        apply(2'b10, 64'h0010_0000_0000_0000);
        // mixed random, every mode, R1..R8
        for (int i = 0; i < 4000; i++) begin
            apply(2'($urandom % 4), rand_operand());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule